// File: doc/BRIEF.md
# Nonvolatile Memory Checksum Engine

This engine walks the low words of a word-addressed nonvolatile memory through a simple request/acknowledge read port and either checks or repairs the image checksum. The checksum rule is a 16-bit sum with wraparound. Every word from address 0 up to and including the checksum word must add up to the signature 16'hBABA.

In check mode the engine reads words 0 through `CSUM_IDX`, adds them and reports pass or mismatch. In repair mode it reads words 0 through `CSUM_IDX-1`. It then issues a single write of `16'hBABA - sum` to address `CSUM_IDX`, so the stored image sums to the signature afterwards. A read fault ends the walk at once. A write fault is also reported. The memory protocol behind the two ports is handled elsewhere.

The controller has six named states:
- `ST_IDLE`: waits for `start_i`.
- `ST_RD_REQ`: holds a read request until it is acknowledged.
- `ST_RD_STEP`: a one-cycle gap in which the next address is formed.
- `ST_EVAL`: compares the sum with the signature in check mode.
- `ST_WR_REQ`: holds the write request until it is acknowledged.
- `ST_FINISH`: pulses done.

Transitions:
- IDLE→RD_REQ on start.
- RD_REQ→RD_STEP on a clean acknowledge that is not the last word.
- RD_REQ→EVAL on the last clean acknowledge in check mode.
- RD_REQ→WR_REQ on the last clean acknowledge in repair mode.
- RD_REQ→FINISH on a faulted acknowledge.
- RD_STEP→RD_REQ.
- EVAL→FINISH.
- WR_REQ→FINISH on the write acknowledge.
- FINISH→IDLE.

Top module: `eesum_engine`

## Requirements
- R1: In check mode (`mode_i`=0) the engine reads addresses 0,1,…,`CSUM_IDX` in ascending order, one read for each address, and adds the data with 16-bit wraparound.
- R2: A check run ends with `status_o`=2'b00 when the wrapped sum equals 16'hBABA, and with 2'b01 otherwise.
- R3: In repair mode (`mode_i`=1) the engine reads addresses 0..`CSUM_IDX-1` in order. It then raises exactly one write request to address `CSUM_IDX` with data 16'hBABA minus the wrapped sum, and ends with `status_o`=2'b00 if the write is acknowledged without fault.
- R4: A read acknowledged with `rd_err_i`=1 stops the walk: no further read and no write is issued, and the run ends in the next cycle with `status_o`=2'b10.
- R5: A write acknowledged with `wr_err_i`=1 ends the run with `status_o`=2'b11.
- R6: Only one read is outstanding at a time. `rd_req_o` stays high with a stable `rd_addr_o` until `rd_ack_i`, then is low for at least the following cycle.
- R7: `busy_o` is high from the cycle after an accepted start through the cycle of `done_o`. `done_o` is a single-cycle pulse, one per run.
- R8: `status_o` holds its final value while idle until the next accepted start. A `start_i` pulse while busy is ignored.
- R9: After reset the engine is idle: `busy_o`, `done_o`, `rd_req_o` and `wr_req_o` are 0 and `status_o` is 2'b00.
- R10: `done_o` rises two cycles after the final read acknowledge of a check run. It rises one cycle after the acknowledge that ends any other run, whether a write acknowledge or a faulted read acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| mode_i | input | 1 | 0 = check, 1 = repair; sampled with start |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read word address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | DATA_W | Read data |
| rd_err_i | input | 1 | Read fault, qualified by acknowledge |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | ADDR_W | Write word address (checksum index) |
| wr_data_o | output | DATA_W | Repair word |
| wr_ack_i | input | 1 | Write acknowledge |
| wr_err_i | input | 1 | Write fault, qualified by acknowledge |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| status_o | output | 2 | 00 pass, 01 mismatch, 10 read fault, 11 write fault |

## Verification
The bench answers each request after a random wait of 0 to 3 cycles and notes the cycle in which it drove each acknowledge. It then requires `done_o` exactly two cycles after the last read acknowledge of a check run, and exactly one cycle after a write acknowledge or a faulted read acknowledge. Inputs change and outputs are sampled on the falling edge. Each value a rising edge produces is therefore read half a period later, and a request seen on one falling edge is answered on that same edge. Status, address order, read count, write data and the idle state one cycle after done are compared with values computed from the bench's own memory image.

// File: rtl/eesum_pkg.sv
package eesum_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_REQ  = 3'd1,
        ST_RD_STEP = 3'd2,
        ST_EVAL    = 3'd3,
        ST_WR_REQ  = 3'd4,
        ST_FINISH  = 3'd5
    } eesum_state_t;

    typedef enum logic [1:0] {
        ES_PASS     = 2'b00,
        ES_MISMATCH = 2'b01,
        ES_RD_FAULT = 2'b10,
        ES_WR_FAULT = 2'b11
    } eesum_status_t;

endpackage

// File: rtl/eesum_walker.sv
// Word address counter for the walk; flags the final address of the run.
module eesum_walker #(
    parameter int ADDR_W   = 8,
    parameter int CSUM_IDX = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic              repair,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [ADDR_W-1:0] LAST_CHECK  = ADDR_W'(CSUM_IDX);
    localparam logic [ADDR_W-1:0] LAST_REPAIR = ADDR_W'(CSUM_IDX - 1);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (clr) begin
            addr_q <= '0;
        end else if (inc) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr    = addr_q;
    assign at_last = repair ? (addr_q == LAST_REPAIR) : (addr_q == LAST_CHECK);

endmodule

// File: rtl/eesum_accum.sv
// Wrapping word adder plus signature compare and repair-word subtractor.
module eesum_accum #(
    parameter int              DATA_W    = 16,
    parameter logic [DATA_W-1:0] SIGNATURE = 16'hBABA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] fix_word,
    output logic              match
);
    logic [DATA_W-1:0] sum_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (clr) begin
            sum_q <= '0;
        end else if (add_en) begin
            sum_q <= sum_q + din;
        end
    end

    assign fix_word = SIGNATURE - sum_q;
    assign match    = (sum_q == SIGNATURE);

endmodule

// File: rtl/eesum_ctrl.sv
// Run sequencer: state register, next-state logic, outputs, status register.
module eesum_ctrl
    import eesum_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_i,
    input  logic          rd_ack_i,
    input  logic          rd_err_i,
    input  logic          wr_ack_i,
    input  logic          wr_err_i,
    input  logic          at_last,
    input  logic          match,
    output logic          repair,
    output logic          rd_req,
    output logic          wr_req,
    output logic          busy,
    output logic          done,
    output logic          clr,
    output logic          add_en,
    output logic          inc,
    output eesum_status_t status
);
    eesum_state_t  state_q, state_d;
    eesum_status_t status_q;
    logic          repair_q;

    logic accept;
    logic rd_ok;
    logic rd_bad;

    assign accept = (state_q == ST_IDLE) && start_i;
    assign rd_ok  = (state_q == ST_RD_REQ) && rd_ack_i && !rd_err_i;
    assign rd_bad = (state_q == ST_RD_REQ) && rd_ack_i && rd_err_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_RD_REQ;
            end
            ST_RD_REQ: begin
                if (rd_ack_i) begin
                    if (rd_err_i)      state_d = ST_FINISH;
                    else if (!at_last) state_d = ST_RD_STEP;
                    else if (repair_q) state_d = ST_WR_REQ;
                    else               state_d = ST_EVAL;
                end
            end
            ST_RD_STEP: state_d = ST_RD_REQ;
            ST_EVAL:    state_d = ST_FINISH;
            ST_WR_REQ: begin
                if (wr_ack_i) state_d = ST_FINISH;
            end
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // mode and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            repair_q <= 1'b0;
            status_q <= ES_PASS;
        end else begin
            if (accept) begin
                repair_q <= mode_i;
                status_q <= ES_PASS;
            end else if (rd_bad) begin
                status_q <= ES_RD_FAULT;
            end else if (state_q == ST_EVAL) begin
                status_q <= match ? ES_PASS : ES_MISMATCH;
            end else if ((state_q == ST_WR_REQ) && wr_ack_i) begin
                status_q <= wr_err_i ? ES_WR_FAULT : ES_PASS;
            end
        end
    end

    // outputs
    always_comb begin
        rd_req = (state_q == ST_RD_REQ);
        wr_req = (state_q == ST_WR_REQ);
        busy   = (state_q != ST_IDLE);
        done   = (state_q == ST_FINISH);
        clr    = accept;
        add_en = rd_ok;
        inc    = rd_ok && !at_last;
        repair = repair_q;
        status = status_q;
    end

endmodule

// File: rtl/eesum_engine.sv
module eesum_engine
    import eesum_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 16,
    parameter int                CSUM_IDX  = 63,
    parameter logic [DATA_W-1:0] SIGNATURE = 16'hBABA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              rd_err_i,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    input  logic              wr_ack_i,
    input  logic              wr_err_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        status_o
);
    localparam logic [ADDR_W-1:0] CSUM_ADDR = ADDR_W'(CSUM_IDX);

    logic          repair;
    logic          clr;
    logic          add_en;
    logic          inc;
    logic          at_last;
    logic          match;
    eesum_status_t status;

    eesum_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .mode_i   (mode_i),
        .rd_ack_i (rd_ack_i),
        .rd_err_i (rd_err_i),
        .wr_ack_i (wr_ack_i),
        .wr_err_i (wr_err_i),
        .at_last  (at_last),
        .match    (match),
        .repair   (repair),
        .rd_req   (rd_req_o),
        .wr_req   (wr_req_o),
        .busy     (busy_o),
        .done     (done_o),
        .clr      (clr),
        .add_en   (add_en),
        .inc      (inc),
        .status   (status)
    );

    eesum_walker #(
        .ADDR_W   (ADDR_W),
        .CSUM_IDX (CSUM_IDX)
    ) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .inc     (inc),
        .repair  (repair),
        .addr    (rd_addr_o),
        .at_last (at_last)
    );

    eesum_accum #(
        .DATA_W    (DATA_W),
        .SIGNATURE (SIGNATURE)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .add_en   (add_en),
        .din      (rd_data_i),
        .fix_word (wr_data_o),
        .match    (match)
    );

    assign wr_addr_o = CSUM_ADDR;
    assign status_o  = status;

endmodule

// File: rtl/eesum_chk.sv
module eesum_chk #(
    parameter int ADDR_W   = 8,
    parameter int CSUM_IDX = 63
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              rd_ack_i,
    input logic              rd_err_i,
    input logic              wr_req_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [1:0]        status_o
);
    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

    // R6
    rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i) |=> !rd_req_o);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_o));

    // R4
    rd_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i && rd_err_i) |=> (done_o && status_o == 2'b10 && !wr_req_o));

    // R3
    wr_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> (wr_addr_o == ADDR_W'(CSUM_IDX) && !rd_req_o));

    // R8
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(status_o));

endmodule

bind eesum_engine eesum_chk #(
    .ADDR_W   (ADDR_W),
    .CSUM_IDX (CSUM_IDX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .rd_ack_i  (rd_ack_i),
    .rd_err_i  (rd_err_i),
    .wr_req_o  (wr_req_o),
    .wr_addr_o (wr_addr_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .status_o  (status_o)
);

// File: tb/sim_eesum_engine.sv
`timescale 1ns/1ps
module sim_eesum_engine;
    localparam int CS = 63;
    localparam logic [15:0] SIG = 16'hBABA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic        rd_ack = 1'b0;
    logic        rd_err = 1'b0;
    logic [15:0] rd_data = 16'h0;
    logic        wr_ack = 1'b0;
    logic        wr_err = 1'b0;
    logic        rd_req_o, wr_req_o, busy_o, done_o;
    logic [7:0]  rd_addr_o, wr_addr_o;
    logic [15:0] wr_data_o;
    logic [1:0]  status_o;

    always #2 clk = ~clk;

    eesum_engine #(.ADDR_W(8), .DATA_W(16), .CSUM_IDX(CS), .SIGNATURE(SIG)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack),
        .rd_data_i(rd_data), .rd_err_i(rd_err),
        .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .wr_ack_i(wr_ack), .wr_err_i(wr_err),
        .busy_o(busy_o), .done_o(done_o), .status_o(status_o)
    );

    int tests = 0;
    int fails = 0;

    logic [15:0] mem [0:CS];

    int          r_reads, r_writes, r_dones, r_lat;
    logic        r_order, r_busy, r_gap, r_after_idle;
    logic [1:0]  r_status;
    logic [7:0]  r_waddr;
    logic [15:0] r_wdata;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] sum_to(input int last);
        logic [15:0] s = 16'h0;
        for (int i = 0; i <= last; i++) s = s + mem[i];
        return s;
    endfunction

    task automatic fill_random();
        for (int i = 0; i <= CS; i++) mem[i] = 16'($urandom);
    endtask

    task automatic run_op(input logic upd, input int err_at, input logic werr, input logic poke);
        int   wait_n;
        int   ack_cyc;
        logic prev_rd;
        logic fin;
        r_reads = 0; r_writes = 0; r_dones = 0; r_lat = -1;
        r_order = 1'b1; r_busy = 1'b1; r_gap = 1'b1; r_status = 2'b00;
        r_waddr = 8'h0; r_wdata = 16'h0;
        wait_n = $urandom_range(0, 3); ack_cyc = 0; prev_rd = 1'b0; fin = 1'b0;
        @(negedge clk);
        mode = upd; start = 1'b1;
        for (int cyc = 0; cyc < 4000 && !fin; cyc++) begin
            @(negedge clk);
            rd_ack = 1'b0; wr_ack = 1'b0; rd_err = 1'b0; wr_err = 1'b0; start = 1'b0;
            if (done_o) begin
                r_dones++;
                r_status = status_o;
                r_lat = cyc - ack_cyc;
                fin = 1'b1;
            end else begin
                if (!busy_o) r_busy = 1'b0;
                if (poke && cyc == 4) start = 1'b1;
                if (rd_req_o && prev_rd) r_gap = 1'b0;
                prev_rd = 1'b0;
                if (rd_req_o) begin
                    if (wait_n > 0) wait_n--;
                    else begin
                        if (int'(rd_addr_o) != r_reads) r_order = 1'b0;
                        rd_data = (int'(rd_addr_o) <= CS) ? mem[rd_addr_o] : 16'h0;
                        rd_err  = (int'(rd_addr_o) == err_at);
                        rd_ack  = 1'b1;
                        r_reads++;
                        ack_cyc = cyc;
                        prev_rd = 1'b1;
                        wait_n  = $urandom_range(0, 3);
                    end
                end
                if (wr_req_o) begin
                    if (wait_n > 0) wait_n--;
                    else begin
                        r_waddr = wr_addr_o;
                        r_wdata = wr_data_o;
                        wr_err  = werr;
                        wr_ack  = 1'b1;
                        r_writes++;
                        ack_cyc = cyc;
                        wait_n  = $urandom_range(0, 3);
                    end
                end
            end
        end
        @(negedge clk);
        rd_ack = 1'b0; wr_ack = 1'b0; rd_err = 1'b0; wr_err = 1'b0;
        r_after_idle = !done_o && !busy_o && (status_o == r_status);
    endtask

    task automatic do_and_check(input logic upd, input int err_at, input logic werr, input logic poke);
        int          e_reads, e_writes, e_lat, last;
        logic [1:0]  e_status;
        logic [15:0] e_wdata;
        last = upd ? CS - 1 : CS;
        e_wdata = SIG - sum_to(CS - 1);
        if (err_at >= 0 && err_at <= last) begin
            e_reads = err_at + 1; e_writes = 0; e_lat = 1; e_status = 2'b10;
        end else if (upd) begin
            e_reads = CS; e_writes = 1; e_lat = 1; e_status = werr ? 2'b11 : 2'b00;
        end else begin
            e_reads = CS + 1; e_writes = 0; e_lat = 2;
            e_status = (sum_to(CS) == SIG) ? 2'b00 : 2'b01;
        end
        run_op(upd, err_at, werr, poke);
        chk(r_status == e_status, "R2 R4 R5 status", int'(r_status), int'(e_status));
        chk(r_reads == e_reads, "R1 R3 R4 read count", r_reads, e_reads);
        chk(r_order, "R1 ascending addresses", int'(r_order), 1);
        chk(r_writes == e_writes, "R3 R4 write count", r_writes, e_writes);
        if (e_writes == 1) begin
            chk(r_wdata == e_wdata, "R3 repair word", int'(r_wdata), int'(e_wdata));
            chk(int'(r_waddr) == CS, "R3 repair address", int'(r_waddr), CS);
        end
        chk(r_lat == e_lat, "R10 done latency", r_lat, e_lat);
        chk(r_dones == 1, "R7 single done", r_dones, 1);
        chk(r_busy, "R7 busy during run", int'(r_busy), 1);
        chk(r_gap, "R6 request gap after ack", int'(r_gap), 1);
        chk(r_after_idle, "R7 R8 idle after done", int'(r_after_idle), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!busy_o && !done_o && !rd_req_o && !wr_req_o, "R9 idle outputs in reset", int'(busy_o), 0);
        chk(status_o == 2'b00, "R9 status in reset", int'(status_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy_o && !rd_req_o && !wr_req_o && status_o == 2'b00, "R9 idle after reset", int'(busy_o), 0);

        // R1 R2: good image passes
        fill_random();
        mem[CS] = SIG - sum_to(CS - 1);
        do_and_check(1'b0, -1, 1'b0, 1'b0);
        // R2: corrupt one word
        mem[5] = mem[5] ^ 16'h0100;
        do_and_check(1'b0, -1, 1'b0, 1'b0);
        // R8: status held while idle
        repeat (10) @(negedge clk);
        chk(status_o == 2'b01 && !busy_o, "R8 mismatch held while idle", int'(status_o), 1);
        // R3: repair then recheck
        do_and_check(1'b1, -1, 1'b0, 1'b0);
        mem[CS] = r_wdata;
        do_and_check(1'b0, -1, 1'b0, 1'b0);
        chk(r_status == 2'b00, "R3 repaired image passes", int'(r_status), 0);
        // wraparound corners
        for (int i = 0; i <= CS; i++) mem[i] = 16'hFFFF;
        do_and_check(1'b0, -1, 1'b0, 1'b0);
        do_and_check(1'b1, -1, 1'b0, 1'b0);
        for (int i = 0; i <= CS; i++) mem[i] = 16'h0000;
        mem[CS] = SIG;
        do_and_check(1'b0, -1, 1'b0, 1'b0);
        // R4: faults at first and last word
        fill_random();
        do_and_check(1'b0, 0, 1'b0, 1'b0);
        do_and_check(1'b0, CS, 1'b0, 1'b0);
        do_and_check(1'b1, CS - 1, 1'b0, 1'b0);
        // R5: write fault
        do_and_check(1'b1, -1, 1'b1, 1'b0);
        // R8: start while busy ignored
        do_and_check(1'b0, -1, 1'b0, 1'b1);
        do_and_check(1'b1, -1, 1'b0, 1'b1);

        // random mix
        for (int n = 0; n < 24; n++) begin
            logic upd, werr, poke;
            int   eat;
            fill_random();
            if ($urandom_range(0, 1) == 1) mem[CS] = SIG - sum_to(CS - 1);
            upd  = 1'($urandom_range(0, 1));
            werr = ($urandom_range(0, 3) == 0);
            poke = ($urandom_range(0, 3) == 0);
            eat  = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, CS)) : -1;
            do_and_check(upd, eat, werr, poke);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule